// File: doc/BRIEF.md
# LED Channel Soft-Start Sequencer

This block is the control state machine for one channel of a switching LED driver. After reset it takes the channel through four states: power-on, an idle state in which software configures the channel, a qualification state that waits until the loop is ready to start, and a soft-start state. In the soft-start state a digital ramp code climbs toward the programmed target current code, and the analog loop uses that code as its reference.

The ramp only advances while the dimming PWM input is high. When PWM goes low the ramp code and the prescaler phase are both frozen, and the next high period picks up from where they stopped. Faults come in two classes and are handled differently. A latched fault sends the channel back to idle and asks software to clear its enable bit. A non-latched fault drops the channel back to qualification and keeps the ramp code it had reached. On every fault exit the block asks for the compensation node to be pulled low.

Top module: `led_ss_seq`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it is raised, the outputs are `chan_on`=0, `comp_pull_low`=1, `ss_code`=0 and `en_clr_req`=0.
- R2: The machine stays idle (`chan_on`=0, `comp_pull_low`=1) until `chan_en`=1 and `target_code` > MIN_CODE (default 8). A code equal to MIN_CODE does not start the channel.
- R3: From qualification the machine enters soft start only in a cycle where `loop_ready`, `dim_pwm` and `target_code` > MIN_CODE are all true. On the next edge `chan_on` goes to 1.
- R4: In soft start, `ss_code` rises by exactly one after every PRESCALE edges (default 4) on which `dim_pwm` is high.
- R5: While `dim_pwm` is low, `ss_code` and the prescaler phase hold. Counting resumes from the held values when `dim_pwm` returns high.
- R6: `ss_code` never increments past `target_code`, and it stays there once it has reached it.
- R7: A non-latched fault during soft start gives `chan_on`=0 and `comp_pull_low`=1 on the next edge and returns the machine to qualification. `ss_code` keeps its value.
- R8: A non-latched fault during qualification keeps the machine there with `comp_pull_low`=1. Once the fault is gone and the start conditions hold, soft start is entered on the next edge.
- R9: A latched fault in qualification or soft start returns the machine to idle on the next edge with `ss_code`=0, `comp_pull_low`=1 and a one-cycle `en_clr_req` pulse.
- R10: Clearing `chan_en` in qualification or soft start returns the machine to idle on the next edge with `chan_on`=0 and `ss_code`=0, and no `en_clr_req`.
- R11: A latched fault wins over a non-latched fault in the same cycle. A fault in the same cycle as a prescaler tick stops that increment.
- R12: `comp_pull_low` is 1 in power-on and idle. It is 0 in qualification and soft start when no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable bit from the register file |
| target_code | input | CODE_W | Target current code |
| dim_pwm | input | 1 | Dimming PWM input |
| loop_ready | input | 1 | Compensation-low ready status |
| flt_latched | input | 1 | Latched fault flag |
| flt_nonlatched | input | 1 | Non-latched fault flag |
| chan_on | output | 1 | Channel on |
| comp_pull_low | output | 1 | Compensation pull-down request |
| ss_code | output | CODE_W | Soft-start ramp DAC code |
| en_clr_req | output | 1 | One-cycle request to clear the enable bit |

## Verification
Two events can fall in the same cycle: a prescaler tick that would raise the ramp code, and a fault that ends soft start. The bench runs the prescaler up to the edge just before a tick and then raises a non-latched fault. The expected result is that the ramp code keeps its old value while the channel turns off. Separately, the bench raises both fault classes together and expects the latched outcome: idle, ramp code cleared, and a clear-request pulse.

// File: rtl/led_ss_pkg.sv
package led_ss_pkg;
  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_QUAL = 2'd2,
    ST_RAMP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/led_ss_prescaler.sv
module led_ss_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [CW-1:0] cnt;
      logic          at_end;
      assign at_end = (cnt == CW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= at_end ? '0 : cnt + 1'b1;
      end
      assign tick = run && at_end;
    end
  endgenerate
endmodule

// File: rtl/led_ss_ramp.sv
module led_ss_ramp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code
);
  logic below;
  assign below = (code < target);

  always_ff @(posedge clk) begin
    if (rst || clear)        code <= '0;
    else if (tick && below)  code <= code + 1'b1;
  end
endmodule

// File: rtl/led_ss_fsm.sv
module led_ss_fsm
  import led_ss_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int MIN_CODE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic [CODE_W-1:0] target_code,
  input  logic              dim_pwm,
  input  logic              loop_ready,
  input  logic              flt_latched,
  input  logic              flt_nonlatched,
  output logic              run,
  output logic              ramp_clear,
  output logic              pre_clear,
  output logic              chan_on,
  output logic              comp_pull_low,
  output logic              en_clr_req
);
  seq_state_t st, nxt;
  logic code_ok, clr_d, flt_d, active;

  assign code_ok = (target_code > CODE_W'(MIN_CODE));
  assign active  = (st == ST_QUAL) || (st == ST_RAMP);

  always_comb begin
    nxt   = st;
    clr_d = 1'b0;
    flt_d = 1'b0;
    unique case (st)
      ST_POR:  nxt = ST_IDLE;
      ST_IDLE: if (chan_en && code_ok) nxt = ST_QUAL;
      ST_QUAL, ST_RAMP: begin
        if (!chan_en) begin
          nxt = ST_IDLE;
        end else if (flt_latched) begin
          nxt   = ST_IDLE;
          clr_d = 1'b1;
          flt_d = 1'b1;
        end else if (flt_nonlatched) begin
          nxt   = ST_QUAL;
          flt_d = 1'b1;
        end else if (st == ST_QUAL && loop_ready && dim_pwm && code_ok) begin
          nxt = ST_RAMP;
        end
      end
      default: nxt = ST_POR;
    endcase
  end

  assign run        = (st == ST_RAMP) && chan_en && !flt_latched && !flt_nonlatched && dim_pwm;
  assign ramp_clear = (nxt == ST_IDLE) && active;
  assign pre_clear  = (nxt != ST_RAMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_POR;
      chan_on       <= 1'b0;
      comp_pull_low <= 1'b1;
      en_clr_req    <= 1'b0;
    end else begin
      st            <= nxt;
      chan_on       <= (nxt == ST_RAMP);
      comp_pull_low <= (nxt == ST_POR) || (nxt == ST_IDLE) || flt_d;
      en_clr_req    <= clr_d;
    end
  end
endmodule

// File: rtl/led_ss_seq.sv
module led_ss_seq #(
  parameter int CODE_W   = 8,
  parameter int MIN_CODE = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic [CODE_W-1:0] target_code,
  input  logic              dim_pwm,
  input  logic              loop_ready,
  input  logic              flt_latched,
  input  logic              flt_nonlatched,
  output logic              chan_on,
  output logic              comp_pull_low,
  output logic [CODE_W-1:0] ss_code,
  output logic              en_clr_req
);
  logic run, ramp_clear, pre_clear, tick;

  led_ss_fsm #(.CODE_W(CODE_W), .MIN_CODE(MIN_CODE)) u_fsm (
    .clk(clk), .rst(rst), .chan_en(chan_en), .target_code(target_code),
    .dim_pwm(dim_pwm), .loop_ready(loop_ready), .flt_latched(flt_latched),
    .flt_nonlatched(flt_nonlatched), .run(run), .ramp_clear(ramp_clear),
    .pre_clear(pre_clear), .chan_on(chan_on), .comp_pull_low(comp_pull_low),
    .en_clr_req(en_clr_req)
  );

  led_ss_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clear(pre_clear), .run(run), .tick(tick)
  );

  led_ss_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst(rst), .clear(ramp_clear), .tick(tick),
    .target(target_code), .code(ss_code)
  );
endmodule

// File: rtl/led_ss_seq_chk.sv
module led_ss_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic [CODE_W-1:0] target_code,
  input logic              dim_pwm,
  input logic              chan_on,
  input logic              comp_pull_low,
  input logic [CODE_W-1:0] ss_code,
  input logic              en_clr_req
);
  // R4: the ramp code moves by one step up, or returns to zero
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
    (ss_code != $past(ss_code)) |-> (ss_code == $past(ss_code) + 1'b1 || ss_code == '0));

  // R5: no advance across an edge where PWM was low while running
  a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
    (chan_on && $past(chan_on) && !$past(dim_pwm)) |-> $stable(ss_code));

  // R6: an increment never passes the target
  a_r6_cap: assert property (@(posedge clk) disable iff (rst)
    (ss_code > $past(ss_code)) |-> (ss_code <= $past(target_code)));

  // R9: clear request is a single-cycle pulse with the channel idle
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    en_clr_req |=> !en_clr_req);
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    en_clr_req |-> (!chan_on && comp_pull_low && ss_code == '0));

  // R10: the channel is on only if enable was set on the previous edge
  a_r10_enable: assert property (@(posedge clk) disable iff (rst)
    chan_on |-> $past(chan_en));

  // R12: no pull-down while running
  a_r12_no_pull: assert property (@(posedge clk) disable iff (rst)
    chan_on |-> !comp_pull_low);

  // R7: every turn-off comes with the pull-down request
  a_r7_off_pull: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_on) |-> comp_pull_low);
endmodule

bind led_ss_seq led_ss_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .target_code(target_code),
  .dim_pwm(dim_pwm), .chan_on(chan_on), .comp_pull_low(comp_pull_low),
  .ss_code(ss_code), .en_clr_req(en_clr_req)
);

// File: tb/sim_led_ss_seq.sv
`timescale 1ns/1ps
module sim_led_ss_seq;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b0, dim_pwm = 1'b0, loop_ready = 1'b0;
  logic flt_latched = 1'b0, flt_nonlatched = 1'b0;
  logic [W-1:0] target_code = '0;
  logic chan_on, comp_pull_low, en_clr_req;
  logic [W-1:0] ss_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit       on;
    bit       pull;
    bit [W-1:0] code;
    bit       clr;
    string    tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  led_ss_seq #(.CODE_W(W), .MIN_CODE(8), .PRESCALE(4)) u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .target_code(target_code),
    .dim_pwm(dim_pwm), .loop_ready(loop_ready), .flt_latched(flt_latched),
    .flt_nonlatched(flt_nonlatched), .chan_on(chan_on),
    .comp_pull_low(comp_pull_low), .ss_code(ss_code), .en_clr_req(en_clr_req)
  );

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(bit on, bit pull, int code, bit clr, string tag);
    exp_t e;
    e.on = on; e.pull = pull; e.code = W'(code); e.clr = clr; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (chan_on !== e.on || comp_pull_low !== e.pull ||
          ss_code !== e.code || en_clr_req !== e.clr) begin
        errors++;
        $display("FAIL %s: actual on=%0b pull=%0b code=%0d clr=%0b expected on=%0b pull=%0b code=%0d clr=%0b",
                 e.tag, chan_on, comp_pull_low, ss_code, en_clr_req,
                 e.on, e.pull, e.code, e.clr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_out(0, 1, 0, 0, "R1 reset state");
    rst = 1'b0;
    step(1);
    expect_out(0, 1, 0, 0, "R12 idle after power-on");
    step(3);
    expect_out(0, 1, 0, 0, "R2 idle without enable");
    chan_en = 1'b1; target_code = 8; dim_pwm = 1'b1;
    step(5);
    expect_out(0, 1, 0, 0, "R2 code equal to threshold holds idle");
    target_code = 12;
    step(1);
    expect_out(0, 0, 0, 0, "R12 qualification without fault");
    step(3);
    expect_out(0, 0, 0, 0, "R3 waits for loop ready");
    loop_ready = 1'b1; dim_pwm = 1'b0;
    step(2);
    expect_out(0, 0, 0, 0, "R3 waits for pwm high");
    dim_pwm = 1'b1;
    step(1);
    expect_out(1, 0, 0, 0, "R3 soft start entered");
    step(3);
    expect_out(1, 0, 0, 0, "R4 no step before prescale");
    step(1);
    expect_out(1, 0, 1, 0, "R4 first step");
    step(4);
    expect_out(1, 0, 2, 0, "R4 second step");
    step(2);
    expect_out(1, 0, 2, 0, "R5 mid-phase");
    dim_pwm = 1'b0;
    step(10);
    expect_out(1, 0, 2, 0, "R5 held while pwm low");
    dim_pwm = 1'b1;
    step(1);
    expect_out(1, 0, 2, 0, "R5 phase kept");
    step(1);
    expect_out(1, 0, 3, 0, "R5 resumes from held phase");
    step(36);
    expect_out(1, 0, 12, 0, "R6 reaches target");
    step(20);
    expect_out(1, 0, 12, 0, "R6 stays at target");
    flt_nonlatched = 1'b1;
    step(1);
    expect_out(0, 1, 12, 0, "R7 non-latched exit keeps code");
    step(4);
    expect_out(0, 1, 12, 0, "R8 held in qualification");
    flt_nonlatched = 1'b0;
    step(1);
    expect_out(1, 0, 12, 0, "R8 restart after fault clears");
    flt_latched = 1'b1; flt_nonlatched = 1'b1;
    step(1);
    expect_out(0, 1, 0, 1, "R11 latched wins, R9 clear request");
    chan_en = 1'b0; flt_latched = 1'b0; flt_nonlatched = 1'b0;
    step(1);
    expect_out(0, 1, 0, 0, "R9 single-cycle request");
    loop_ready = 1'b0; chan_en = 1'b1;
    step(1);
    expect_out(0, 0, 0, 0, "R12 qualification again");
    flt_latched = 1'b1;
    step(1);
    expect_out(0, 1, 0, 1, "R9 latched in qualification");
    chan_en = 1'b0; flt_latched = 1'b0;
    step(1);
    expect_out(0, 1, 0, 0, "R9 request ends");
    chan_en = 1'b1; loop_ready = 1'b1; dim_pwm = 1'b1;
    step(2);
    expect_out(1, 0, 0, 0, "R3 second entry from zero");
    step(7);
    expect_out(1, 0, 1, 0, "R4 one step before coincidence");
    flt_nonlatched = 1'b1;
    step(1);
    expect_out(0, 1, 1, 0, "R11 fault blocks coinciding tick");
    flt_nonlatched = 1'b0;
    step(1);
    expect_out(1, 0, 1, 0, "R7 resumes from held code");
    step(4);
    expect_out(1, 0, 2, 0, "R4 step after restart");
    chan_en = 1'b0;
    step(1);
    expect_out(0, 1, 0, 0, "R10 disable returns to idle");
    step(3);
    expect_out(0, 1, 0, 0, "R10 remains idle");
    step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule